// File: doc/BRIEF.md
# Dual-Direction Universal Bus Register

This block is an 18-bit, two-port registered transceiver. Data moves from port A to port B through one storage path and from port B to port A through a second, fully separate path. Each path has one storage element per bit. That element can pass data straight through (transparent), hold a value (latched), capture on the falling edge of the path's strobe (clocked), or capture only when the path's active-low capture enable allows it (clock-enabled). Each direction has its own active-low output enable, which either drives the port or releases it.

Inside a synchronous chip the per-direction strobe is an ordinary signal sampled by the system clock. A falling strobe edge is seen when the strobe was high at one system clock edge and is low at the next. Each output port comes out as an 18-bit data vector plus an 18-bit drive-enable vector, so the surrounding logic (or a bench) can resolve the pad to high impedance. While a path is transparent its storage follows the input on every system clock edge. When the latch enable drops, the path therefore keeps the input taken at the last edge where the latch enable was high.

Top module: `ubr_dual`

## Requirements
- R1: A synchronous active-low reset clears both storage paths to zero, so with latch enable low every data output reads 0 after reset.
- R2: While a direction's latch enable is 1, its data output equals its input in the same cycle, with no register delay.
- R3: While a direction's latch enable is 0 and no falling strobe edge is seen, its data output keeps its value from one cycle to the next, whatever the input does.
- R4: When the latch enable goes from 1 to 0, the output shows the input sampled at the last system clock edge where the latch enable was 1.
- R5: With latch enable 0 and capture enable (active low) at 0, a strobe sampled 1 at one clock edge and 0 at the next stores the input present at that second edge. The new value appears on the output after that edge.
- R6: With capture enable at 1, a falling strobe edge stores nothing and the output keeps its value.
- R7: The drive-enable vector of a port is all ones when that direction's output enable is 0 and all zeros when it is 1. The data vector is unaffected by the output enable.
- R8: The A-to-B controls never change the B-to-A path, and the B-to-A controls never change the A-to-B path. For example, one path can be clocked while the other is transparent.
- R9: A rising strobe edge (sampled 0 then 1) stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data driven onto port A by the B-to-A path |
| a_oe | output | 18 | Per-bit drive enable for port A |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data driven onto port B by the A-to-B path |
| b_oe | output | 18 | Per-bit drive enable for port B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B capture strobe, falling edge captures |
| ab_ce_n | input | 1 | A-to-B capture enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A capture strobe, falling edge captures |
| ba_ce_n | input | 1 | B-to-A capture enable, active low |

## Verification
A falling strobe edge can arrive in the same cycle that the latch enable drops. The storage must then take the input of that cycle instead of keeping the value it last followed. The random phase toggles latch enable, strobe and capture enable on every cycle with independent probabilities, so this overlap happens many times in both directions. Every cycle is judged against a bench reference model, which applies the transparent rule first and the edge-capture rule second.

// File: rtl/ubr_pkg.sv
// Package: shared types for the dual-direction universal bus register.
// Assumes: controls of each direction are grouped into one struct.
package ubr_pkg;

    // Control bundle for one transfer direction.
    typedef struct packed {
        logic oe_n;   // output enable, active low
        logic le;     // latch enable, 1 = transparent
        logic stb;    // capture strobe, falling edge captures
        logic ce_n;   // capture enable, active low
    } ubr_ctrl_t;

endpackage

// File: rtl/ubr_fall_det.sv
// Module: falling-edge detector for a strobe sampled by the system clock.
// Assumes: the strobe is synchronous to clk; reset clears the history to 0,
// so no edge is reported in the first cycle after reset.
module ubr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic fall
);

    logic stb_q;

    // Keep the strobe value seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= stb;
    end

    // A fall is high then low on consecutive samples.
    always_comb fall = stb_q & ~stb;

endmodule

// File: rtl/ubr_cell.sv
// Module: one storage bit that behaves as a transparent latch or a flip-flop.
// Assumes: follow and capture are decided by the parent path; while follow
// is set the stored bit tracks the input on every clock edge.
module ubr_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    input  logic follow,
    input  logic capture,
    output logic q
);

    logic store;

    // Load on follow or capture, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                 store <= 1'b0;
        else if (follow || capture) store <= d;
    end

    // Transparent view while following, stored view otherwise.
    always_comb q = follow ? d : store;

endmodule

// File: rtl/ubr_drive.sv
// Module: output stage that produces data plus a per-bit drive enable.
// Assumes: the pad resolution to high impedance happens outside the block.
module ubr_drive #(
    parameter int W = 18
) (
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] en
);

    // Data passes through; the enable is broadcast to every bit.
    always_comb begin
        dout = din;
        en   = {W{~oe_n}};
    end

endmodule

// File: rtl/ubr_path.sv
// Module: one transfer direction, with the edge detect, W storage cells and the drive stage.
// Assumes: controls are synchronous to clk.
module ubr_path
    import ubr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ubr_ctrl_t    ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] en
);

    logic         fall;
    logic         cap;
    logic [W-1:0] view;

    ubr_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (ctl.stb),
        .fall  (fall)
    );

    // Edge capture counts only when latched and enabled.
    always_comb cap = fall & ~ctl.ce_n & ~ctl.le;

    for (genvar i = 0; i < W; i++) begin : g_bit
        ubr_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .d       (din[i]),
            .follow  (ctl.le),
            .capture (cap),
            .q       (view[i])
        );
    end

    ubr_drive #(.W(W)) u_drv (
        .oe_n (ctl.oe_n),
        .din  (view),
        .dout (dout),
        .en   (en)
    );

endmodule

// File: rtl/ubr_dual.sv
// Module: top of the dual-direction universal bus register.
// Assumes: the A-to-B and B-to-A paths share only clock and reset.
module ubr_dual
    import ubr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_stb,
    input  logic         ab_ce_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_stb,
    input  logic         ba_ce_n
);

    ubr_ctrl_t ab_ctl;
    ubr_ctrl_t ba_ctl;

    // Bundle each direction's controls.
    always_comb begin
        ab_ctl = '{oe_n: ab_oe_n, le: ab_le, stb: ab_stb, ce_n: ab_ce_n};
        ba_ctl = '{oe_n: ba_oe_n, le: ba_le, stb: ba_stb, ce_n: ba_ce_n};
    end

    ubr_path #(.W(W)) u_ab (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ab_ctl),
        .din   (a_in),
        .dout  (b_out),
        .en    (b_oe)
    );

    ubr_path #(.W(W)) u_ba (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ba_ctl),
        .din   (b_in),
        .dout  (a_out),
        .en    (a_oe)
    );

endmodule

// File: rtl/ubr_dual_chk.sv
// Module: assertion checker for ubr_dual, attached with bind.
// Assumes: checks are sampled on clk and disabled during reset.
module ubr_dual_chk #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] a_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_in,
    input logic [W-1:0] b_out,
    input logic [W-1:0] b_oe,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_stb,
    input logic         ab_ce_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_stb,
    input logic         ba_ce_n
);

    a_r2_ab_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> b_out == a_in);
    a_r2_ba_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> a_out == b_in);

    a_r7_ab_enable: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe == {W{~ab_oe_n}});
    a_r7_ba_enable: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe == {W{~ba_oe_n}});

    a_r3_ab_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !(!ab_ce_n && $past(ab_stb) && !ab_stb)) |=> (ab_le || $stable(b_out)));
    a_r3_ba_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !(!ba_ce_n && $past(ba_stb) && !ba_stb)) |=> (ba_le || $stable(a_out)));

    a_r5_ab_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_le && !ab_ce_n && $past(ab_stb) && !ab_stb)
        |=> (ab_le || b_out == $past(a_in)));
    a_r5_ba_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ba_le && !ba_ce_n && $past(ba_stb) && !ba_stb)
        |=> (ba_le || a_out == $past(b_in)));

    a_r6_ab_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && ab_ce_n) |=> (ab_le || $stable(b_out)));
    a_r6_ba_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && ba_ce_n) |=> (ba_le || $stable(a_out)));

    a_r4_ab_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ab_le)) |-> b_out == $past(a_in));
    a_r4_ba_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(ba_le)) |-> a_out == $past(b_in));

endmodule

bind ubr_dual ubr_dual_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_in    (a_in),
    .a_out   (a_out),
    .a_oe    (a_oe),
    .b_in    (b_in),
    .b_out   (b_out),
    .b_oe    (b_oe),
    .ab_oe_n (ab_oe_n),
    .ab_le   (ab_le),
    .ab_stb  (ab_stb),
    .ab_ce_n (ab_ce_n),
    .ba_oe_n (ba_oe_n),
    .ba_le   (ba_le),
    .ba_stb  (ba_stb),
    .ba_ce_n (ba_ce_n)
);

// File: tb/sim_ubr_dual.sv
`timescale 1ns/1ps
module sim_ubr_dual;

    localparam int W = 18;
    localparam int MAXCYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic ab_oe_n = 1'b0, ab_le = 1'b0, ab_stb = 1'b0, ab_ce_n = 1'b0;
    logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_stb = 1'b0, ba_ce_n = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ubr_dual #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_stb(ab_stb), .ab_ce_n(ab_ce_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb), .ba_ce_n(ba_ce_n)
    );

    // Resolved port B pad, released when the drive enable is low.
    wire [W-1:0] b_pad;
    for (genvar i = 0; i < W; i++) begin : g_pad
        assign b_pad[i] = b_oe[i] ? b_out[i] : 1'bz;
    end

    // Reference next-state rule taken from the requirements.
    function automatic logic [W-1:0] ref_next(logic le, logic ce_n, logic q, logic s,
                                              logic [W-1:0] d, logic [W-1:0] old);
        if (le) return d;
        if (!ce_n && q && !s) return d;
        return old;
    endfunction

    logic [W-1:0] m_ab = '0, m_ba = '0;
    logic m_abq = 1'b0, m_baq = 1'b0;

    // Reference model state, updated on each system clock edge.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_ab <= '0; m_ba <= '0; m_abq <= 1'b0; m_baq <= 1'b0;
        end else begin
            m_ab  <= ref_next(ab_le, ab_ce_n, m_abq, ab_stb, a_in, m_ab);
            m_ba  <= ref_next(ba_le, ba_ce_n, m_baq, ba_stb, b_in, m_ba);
            m_abq <= ab_stb;
            m_baq <= ba_stb;
        end
    end

    task automatic chk_val(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare all outputs with the reference model.
    task automatic chk_all(string tag);
        logic [W-1:0] eb, ea;
        eb = ab_le ? a_in : m_ab;
        ea = ba_le ? b_in : m_ba;
        chk_val({tag, " b_out"}, b_out, eb);
        chk_val({tag, " a_out"}, a_out, ea);
        chk_val("R7 b_oe", b_oe, {W{~ab_oe_n}});
        chk_val("R7 a_oe", a_oe, {W{~ba_oe_n}});
        if (!ab_oe_n) chk_val({tag, " b_pad"}, b_pad, eb);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) step();
        rst_n = 1'b1;
        #1;
        chk_val("R1 b_out reset", b_out, '0);
        chk_val("R1 a_out reset", a_out, '0);

        // R2 transparent both directions
        step(); ab_le = 1; ba_le = 1; a_in = 18'h2A5A5; b_in = 18'h15A5A; #1;
        chk_val("R2 b_out", b_out, 18'h2A5A5);
        chk_val("R2 a_out", a_out, 18'h15A5A);
        a_in = 18'h00FFF; #0.5;
        chk_val("R2 same cycle", b_out, 18'h00FFF);

        // R4 latch enable drop keeps last followed input
        step(); ab_le = 0; a_in = 18'h3FFFF; #1;
        chk_val("R4 drop", b_out, 18'h00FFF);

        // R3 hold while input changes
        step(); a_in = 18'h12345; #1;
        chk_val("R3 hold", b_out, 18'h00FFF);

        // R5 falling strobe capture
        step(); ab_stb = 1; ab_ce_n = 0; a_in = 18'h0ABCD; #1;
        chk_val("R9 no capture on hold", b_out, 18'h00FFF);
        step(); ab_stb = 0; a_in = 18'h2BEEF; #1;
        chk_all("R5 pre");
        step(); a_in = 18'h00001; #1;
        chk_val("R5 capture", b_out, 18'h2BEEF);

        // R9 rising edge stores nothing
        step(); ab_stb = 1; a_in = 18'h11111; #1;
        step(); a_in = 18'h22222; #1;
        chk_val("R9 rising", b_out, 18'h2BEEF);

        // R6 capture enable high blocks a falling edge
        step(); ab_ce_n = 1; ab_stb = 0; a_in = 18'h33333; #1;
        step(); #1;
        chk_val("R6 gated", b_out, 18'h2BEEF);

        // R7 output enable
        step(); ab_oe_n = 1; #1;
        chk_val("R7 off", b_oe, '0);
        chk_val("R7 data kept", b_out, 18'h2BEEF);
        step(); ab_oe_n = 0; #1;
        chk_val("R7 on", b_oe, '1);

        // R8 clocked A-to-B while B-to-A transparent
        step(); ab_ce_n = 0; ab_stb = 1; ba_le = 1; b_in = 18'h0F0F0; #1;
        step(); ab_stb = 0; a_in = 18'h30303; b_in = 18'h01234; #1;
        chk_val("R8 ba transparent", a_out, 18'h01234);
        step(); a_in = 18'h0; #1;
        chk_val("R8 ab clocked", b_out, 18'h30303);
        chk_val("R8 ba unaffected", a_out, 18'h01234);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            step();
            ab_le   = ($urandom_range(3) == 0);
            ba_le   = ($urandom_range(3) == 0);
            ab_stb  = $urandom_range(1);
            ba_stb  = $urandom_range(1);
            ab_ce_n = ($urandom_range(2) == 0);
            ba_ce_n = ($urandom_range(2) == 0);
            ab_oe_n = ($urandom_range(3) == 0);
            ba_oe_n = ($urandom_range(3) == 0);
            a_in    = W'($urandom);
            b_in    = W'($urandom);
            #1;
            chk_all(ab_le ? "R2 rand" : "R5 rand");
        end
        // R8 random independence is covered by per-direction comparison above
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    initial begin
        wait (cycles >= MAXCYC);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule